// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the device side of a byte-wide flash part with an 18-bit address space. It watches each bus write (address plus data byte) and recognises the multi-cycle unlock sequences that select an operation. When a sequence completes, it raises a one-cycle request to the array engine that carries an operation code and the address and data of the write that completed it. The operations are return-to-read, identifier entry, byte program, chip erase, sector erase, erase suspend, erase resume and sector append.

The decoder keeps the device mode. The modes are read array, identifier, busy and erase-suspended. An abstract array engine reports completion through a done pulse. While the device is in identifier mode, a small read-side decoder supplies the manufacturer code, the device code or a per-sector protection flag. Which one depends on the low bits of the read address.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, `cur_mode` is read (code 0), `req_valid` is low and `erase_set` is zero.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then any address/data produce a request with op code 2 (program). The request appears in the cycle after the fourth write and carries that write's address and data, and the mode becomes busy (code 2). In unlock cycles only address bits 10:0 are compared.
- R3: A write whose address/data pair does not fit the sequence in progress produces no request. It returns the mode to read (code 0) and restarts the sequence.
- R4: The third cycle 0x555/0x90 gives op code 1 and identifier mode (code 1). In that mode `id_rdata` is 0xC2 when `rd_addr[1:0]`=0 and DEV_CODE (default 0xB0) when it is 1. In every other mode `id_rdata` is 0.
- R5: In identifier mode, `rd_addr[1:0]`=2 reads 0x01 if the `prot_mask` bit of the sector holding `rd_addr` is set, and 0x00 if it is not.
- R6: A write of 0xF0 from read or identifier mode at any point of a sequence, other than the program data cycle, gives op code 0. A write of 0xF0 in busy mode does the same. Either way the mode becomes read and `erase_set` clears. In the program data cycle, 0xF0 is ordinary program data.
- R7: The writes 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10 after the two unlock cycles give op code 3. `erase_set` becomes all ones and the mode becomes busy.
- R8: The same prefix followed by any address with data 0x30 gives op code 4. `erase_set` becomes one-hot on the sector holding that address. With the default layout, bits 0..2 are the 64K sectors at 0x00000, 0x10000 and 0x20000, bit 3 is the 32K sector at 0x30000, bits 4 and 5 are the 8K sectors at 0x38000 and 0x3A000, and bit 6 is the 16K sector at 0x3C000. `erase_set` keeps its value after completion until the next erase or 0xF0.
- R9: A 0x30 write no more than APPEND_WIN cycles after the last accepted sector gives op code 7 and ORs that sector into `erase_set`. It also restarts the window. Once the window has expired, 0x30 has no effect.
- R10: 0xB0 during a running sector erase gives op code 5 and suspended mode (code 3). 0xB0 at any other time has no effect.
- R11: In suspended mode, 0x30 gives op code 6 and busy mode. Every other write, 0xF0 included, has no effect.
- R12: In busy mode, writes other than those in R6, R9 and R10 are ignored. An `eng_done` pulse returns the mode to read.
- R13: `req_valid` is high only in the cycle that follows a write, and only for one cycle per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| eng_done | input | 1 | Array engine completion pulse |
| prot_mask | input | 7 | Per-sector protection flags |
| rd_addr | input | 18 | Read address for identifier mode |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 3 | Operation code (0 read,1 ident,2 program,3 chip,4 sector,5 suspend,6 resume,7 append) |
| req_addr | output | 18 | Address of the completing write |
| req_data | output | 8 | Data of the completing write |
| erase_set | output | 7 | Sectors selected for erase |
| cur_mode | output | 2 | Mode (0 read,1 ident,2 busy,3 suspended) |
| id_rdata | output | 8 | Identifier-mode read data |

## Verification
The hardest state to reach is a suspended sector erase whose erase set holds more than one sector. To get there, a six-write erase sequence must be followed by a second 0x30 write that falls inside the append window, and then by 0xB0 before the engine reports completion. The directed part of the bench drives that chain and then probes the suspended state with writes that must be ignored. It then resumes, lets the window run out, and shows that a late 0x30 leaves `erase_set` unchanged.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
   localparam int NSECT = 7;

   typedef enum logic [2:0] {
      OP_READ = 3'd0, OP_IDENT = 3'd1, OP_PROG = 3'd2, OP_CHIP = 3'd3,
      OP_SECT = 3'd4, OP_SUSP = 3'd5, OP_RESUME = 3'd6, OP_ADD = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      M_READ = 2'd0, M_IDENT = 2'd1, M_BUSY = 2'd2, M_SUSP = 2'd3
   } mode_e;

   typedef enum logic [2:0] {
      S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5
   } seq_e;

   localparam logic [7:0] D_KEY1  = 8'hAA;
   localparam logic [7:0] D_KEY2  = 8'h55;
   localparam logic [7:0] D_PGM   = 8'hA0;
   localparam logic [7:0] D_ERA   = 8'h80;
   localparam logic [7:0] D_IDENT = 8'h90;
   localparam logic [7:0] D_CHIP  = 8'h10;
   localparam logic [7:0] D_SECT  = 8'h30;
   localparam logic [7:0] D_RST   = 8'hF0;
   localparam logic [7:0] D_SUSP  = 8'hB0;
endpackage

// File: rtl/fcmd_sector.sv
module fcmd_sector #(
   parameter int ADDR_W   = 18,
   parameter bit TOP_BOOT = 1'b1
) (
   input  logic [ADDR_W-1:0]         addr,
   output logic [fcmd_pkg::NSECT-1:0] onehot
);
   logic [4:0] a;
   logic [2:0] idx;

   assign a = addr[ADDR_W-1 -: 5];

   generate
      if (TOP_BOOT) begin : g_top
         always_comb begin
            if (a[4:3] != 2'd3)      idx = {1'b0, a[4:3]};
            else if (!a[2])          idx = 3'd3;
            else if (a[1:0] == 2'd0) idx = 3'd4;
            else if (a[1:0] == 2'd1) idx = 3'd5;
            else                     idx = 3'd6;
         end
      end else begin : g_bottom
         always_comb begin
            if (a[4:3] != 2'd0) idx = {1'b0, a[4:3]} + 3'd3;
            else if (a[2])      idx = 3'd3;
            else if (!a[1])     idx = 3'd0;
            else if (!a[0])     idx = 3'd1;
            else                idx = 3'd2;
         end
      end
   endgenerate

   assign onehot = fcmd_pkg::NSECT'(1) << idx;
endmodule

// File: rtl/fcmd_idread.sv
module fcmd_idread #(
   parameter int         ADDR_W   = 18,
   parameter bit         TOP_BOOT = 1'b1,
   parameter logic [7:0] MFR_CODE = 8'hC2,
   parameter logic [7:0] DEV_CODE = 8'hB0
) (
   input  logic                       ident_on,
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic [fcmd_pkg::NSECT-1:0] prot_mask,
   output logic [7:0]                 rdata
);
   logic [fcmd_pkg::NSECT-1:0] rd_sec;

   fcmd_sector #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_rd_sec (
      .addr(rd_addr), .onehot(rd_sec)
   );

   always_comb begin
      rdata = 8'h00;
      if (ident_on) begin
         case (rd_addr[1:0])
            2'd0:    rdata = MFR_CODE;
            2'd1:    rdata = DEV_CODE;
            2'd2:    rdata = {7'd0, |(prot_mask & rd_sec)};
            default: rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
   import fcmd_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int MATCH_W    = 11,
   parameter int APPEND_WIN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [NSECT-1:0]  wr_sec,
   input  logic              eng_done,
   output logic              req_valid,
   output op_e               req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic [NSECT-1:0]  erase_set,
   output mode_e             mode
);
   localparam int WIN_W = $clog2(APPEND_WIN + 1);
   localparam logic [MATCH_W-1:0] A_ONE = MATCH_W'(11'h555);
   localparam logic [MATCH_W-1:0] A_TWO = MATCH_W'(11'h2AA);

   seq_e             seq, nxt;
   logic             hit, fail, sec_run;
   op_e              hop;
   logic [WIN_W-1:0] win;
   logic             at1, at2;

   assign at1 = (wr_addr[MATCH_W-1:0] == A_ONE);
   assign at2 = (wr_addr[MATCH_W-1:0] == A_TWO);

   always_comb begin
      nxt  = S_IDLE;
      hit  = 1'b0;
      fail = 1'b0;
      hop  = OP_READ;
      if (seq != S_PGM && wr_data == D_RST) begin
         hit = 1'b1;
      end else begin
         case (seq)
            S_IDLE: if (at1 && wr_data == D_KEY1) nxt = S_U1; else fail = 1'b1;
            S_U1:   if (at2 && wr_data == D_KEY2) nxt = S_U2; else fail = 1'b1;
            S_U2: begin
               if (at1 && wr_data == D_PGM)        nxt = S_PGM;
               else if (at1 && wr_data == D_ERA)   nxt = S_E3;
               else if (at1 && wr_data == D_IDENT) begin hit = 1'b1; hop = OP_IDENT; end
               else fail = 1'b1;
            end
            S_PGM: begin hit = 1'b1; hop = OP_PROG; end
            S_E3:   if (at1 && wr_data == D_KEY1) nxt = S_E4; else fail = 1'b1;
            S_E4:   if (at2 && wr_data == D_KEY2) nxt = S_E5; else fail = 1'b1;
            S_E5: begin
               if (at1 && wr_data == D_CHIP)  begin hit = 1'b1; hop = OP_CHIP; end
               else if (wr_data == D_SECT)    begin hit = 1'b1; hop = OP_SECT; end
               else fail = 1'b1;
            end
            default: fail = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq       <= S_IDLE;
         mode      <= M_READ;
         req_valid <= 1'b0;
         req_op    <= OP_READ;
         req_addr  <= '0;
         req_data  <= '0;
         erase_set <= '0;
         sec_run   <= 1'b0;
         win       <= '0;
      end else begin
         req_valid <= 1'b0;
         if (win != '0) win <= win - 1'b1;
         if (wr_en) begin
            req_addr <= wr_addr;
            req_data <= wr_data;
            case (mode)
               M_BUSY: begin
                  if (wr_data == D_RST) begin
                     req_valid <= 1'b1; req_op <= OP_READ; mode <= M_READ;
                     erase_set <= '0; sec_run <= 1'b0; win <= '0;
                  end else if (sec_run && win != '0 && wr_data == D_SECT) begin
                     req_valid <= 1'b1; req_op <= OP_ADD;
                     erase_set <= erase_set | wr_sec;
                     win       <= WIN_W'(APPEND_WIN);
                  end else if (sec_run && wr_data == D_SUSP) begin
                     req_valid <= 1'b1; req_op <= OP_SUSP; mode <= M_SUSP; win <= '0;
                  end else if (eng_done) begin
                     mode <= M_READ; sec_run <= 1'b0; win <= '0;
                  end
               end
               M_SUSP: begin
                  if (wr_data == D_SECT) begin
                     req_valid <= 1'b1; req_op <= OP_RESUME; mode <= M_BUSY;
                  end
               end
               default: begin
                  seq <= nxt;
                  if (fail) mode <= M_READ;
                  if (hit) begin
                     req_valid <= 1'b1;
                     req_op    <= hop;
                     case (hop)
                        OP_IDENT: mode <= M_IDENT;
                        OP_PROG:  mode <= M_BUSY;
                        OP_CHIP: begin mode <= M_BUSY; erase_set <= '1; sec_run <= 1'b0; end
                        OP_SECT: begin
                           mode <= M_BUSY; erase_set <= wr_sec; sec_run <= 1'b1;
                           win  <= WIN_W'(APPEND_WIN);
                        end
                        default: begin mode <= M_READ; erase_set <= '0; end
                     endcase
                  end
               end
            endcase
         end else if (eng_done && mode == M_BUSY) begin
            mode <= M_READ; sec_run <= 1'b0; win <= '0;
         end
      end
   end
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder #(
   parameter int         ADDR_W     = 18,
   parameter int         MATCH_W    = 11,
   parameter int         APPEND_WIN = 8,
   parameter bit         TOP_BOOT   = 1'b1,
   parameter logic [7:0] MFR_CODE   = 8'hC2,
   parameter logic [7:0] DEV_CODE   = 8'hB0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              eng_done,
   input  logic [6:0]        prot_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              req_valid,
   output logic [2:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic [6:0]        erase_set,
   output logic [1:0]        cur_mode,
   output logic [7:0]        id_rdata
);
   import fcmd_pkg::*;

   generate
      if (MATCH_W < 10 || MATCH_W > ADDR_W) begin : g_bad_match
         $error("MATCH_W must lie between 10 and ADDR_W");
      end
      if (ADDR_W < 13) begin : g_bad_addr
         $error("ADDR_W too small for the sector layout");
      end
      if (APPEND_WIN < 1) begin : g_bad_win
         $error("APPEND_WIN must be at least 1");
      end
   endgenerate

   logic [NSECT-1:0] wr_sec;
   op_e              op_q;
   mode_e            mode_q;

   fcmd_sector #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_wr_sec (
      .addr(wr_addr), .onehot(wr_sec)
   );

   fcmd_ctrl #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W), .APPEND_WIN(APPEND_WIN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_sec(wr_sec), .eng_done(eng_done), .req_valid(req_valid), .req_op(op_q),
      .req_addr(req_addr), .req_data(req_data), .erase_set(erase_set), .mode(mode_q)
   );

   fcmd_idread #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT), .MFR_CODE(MFR_CODE),
                 .DEV_CODE(DEV_CODE)) u_idread (
      .ident_on(mode_q == M_IDENT), .rd_addr(rd_addr), .prot_mask(prot_mask),
      .rdata(id_rdata)
   );

   assign req_op   = op_q;
   assign cur_mode = mode_q;
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
   parameter logic [7:0] MFR_CODE = 8'hC2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       eng_done,
   input logic [1:0] rd_low,
   input logic       req_valid,
   input logic [2:0] req_op,
   input logic [6:0] erase_set,
   input logic [1:0] cur_mode,
   input logic [7:0] id_rdata
);
   p_rst_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cur_mode == 2'd0 && !req_valid));

   p_ident_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd1 && rd_low == 2'd0) |-> (id_rdata == MFR_CODE));

   p_reset_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd0) |-> (cur_mode == 2'd0 && erase_set == 7'd0));

   p_chip_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd3) |-> (erase_set == 7'h7F && cur_mode == 2'd2));

   p_suspend_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd5) |-> (cur_mode == 2'd3));

   p_susp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd3 && wr_en && wr_data != 8'h30) |=> (cur_mode == 2'd3 && !req_valid));

   p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd2 && wr_en && !eng_done && wr_data != 8'hF0 && wr_data != 8'hB0
       && wr_data != 8'h30) |=> (cur_mode == 2'd2 && !req_valid));

   p_req_after_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(wr_en));
endmodule

bind fcmd_decoder fcmd_chk #(.MFR_CODE(MFR_CODE)) u_fcmd_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .eng_done(eng_done),
   .rd_low(rd_addr[1:0]), .req_valid(req_valid), .req_op(req_op),
   .erase_set(erase_set), .cur_mode(cur_mode), .id_rdata(id_rdata)
);

// File: tb/test_fcmd_decoder.sv
module test_fcmd_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int NROW = 21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [17:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        eng_done = 1'b0;
   logic [6:0]  prot_mask = 7'b0100100;
   logic [17:0] rd_addr = '0;
   logic        req_valid;
   logic [2:0]  req_op;
   logic [17:0] req_addr;
   logic [7:0]  req_data;
   logic [6:0]  erase_set;
   logic [1:0]  cur_mode;
   logic [7:0]  id_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   fcmd_decoder i_fcmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .eng_done(eng_done), .prot_mask(prot_mask), .rd_addr(rd_addr),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .erase_set(erase_set), .cur_mode(cur_mode), .id_rdata(id_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [33:0] v(input logic w, input logic [17:0] a, input logic [7:0] d,
                                     input logic dn, input logic ev, input logic [2:0] op,
                                     input logic [1:0] md);
      return {w, a, d, dn, ev, op, md};
   endfunction

   localparam logic [33:0] TBL [NROW] = '{
      v(1, 18'h00555, 8'hAA, 0, 0, 3'd0, 2'd0),
      v(1, 18'h002AA, 8'h55, 0, 0, 3'd0, 2'd0),
      v(1, 18'h00555, 8'hA0, 0, 0, 3'd0, 2'd0),
      v(1, 18'h32345, 8'h5A, 0, 1, 3'd2, 2'd2),
      v(1, 18'h00555, 8'hB0, 0, 0, 3'd0, 2'd2),
      v(1, 18'h00555, 8'hAA, 0, 0, 3'd0, 2'd2),
      v(0, 18'h00000, 8'h00, 1, 0, 3'd0, 2'd0),
      v(1, 18'h3F555, 8'hAA, 0, 0, 3'd0, 2'd0),
      v(1, 18'h1A2AA, 8'h55, 0, 0, 3'd0, 2'd0),
      v(1, 18'h00555, 8'h90, 0, 1, 3'd1, 2'd1),
      v(1, 18'h00555, 8'hAA, 0, 0, 3'd0, 2'd1),
      v(1, 18'h00123, 8'h55, 0, 0, 3'd0, 2'd0),
      v(1, 18'h00555, 8'hAA, 0, 0, 3'd0, 2'd0),
      v(1, 18'h002AA, 8'h55, 0, 0, 3'd0, 2'd0),
      v(1, 18'h00555, 8'h80, 0, 0, 3'd0, 2'd0),
      v(1, 18'h00555, 8'hAA, 0, 0, 3'd0, 2'd0),
      v(1, 18'h002AA, 8'h55, 0, 0, 3'd0, 2'd0),
      v(1, 18'h00555, 8'h10, 0, 1, 3'd3, 2'd2),
      v(0, 18'h00000, 8'h00, 1, 0, 3'd0, 2'd0),
      v(1, 18'h00000, 8'hB0, 0, 0, 3'd0, 2'd0),
      v(1, 18'h00000, 8'h30, 0, 0, 3'd0, 2'd0)
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [17:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(18'h00555, 8'hAA);
      wr(18'h002AA, 8'h55);
   endtask

   task automatic erase_prefix();
      unlock();
      wr(18'h00555, 8'h80);
      unlock();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 mode after reset", cur_mode, 2'd0);
      chk("R1 req_valid after reset", req_valid, 1'b0);
      chk("R1 erase_set after reset", erase_set, 7'd0);

      for (int i = 0; i < NROW; i++) begin
         @(negedge clk);
         wr_en = TBL[i][33]; wr_addr = TBL[i][32:15]; wr_data = TBL[i][14:7];
         eng_done = TBL[i][6];
         @(negedge clk);
         wr_en = 1'b0; eng_done = 1'b0;
         chk($sformatf("table row %0d valid (R2 R3 R7 R10 R12)", i), req_valid, TBL[i][5]);
         if (TBL[i][5]) chk($sformatf("table row %0d op (R2 R4 R7)", i), req_op, TBL[i][4:2]);
         chk($sformatf("table row %0d mode (R3 R12)", i), cur_mode, TBL[i][1:0]);
      end

      // R4 / R5: identifier reads
      unlock();
      wr(18'h00555, 8'h90);
      chk("R4 ident mode", cur_mode, 2'd1);
      rd_addr = 18'h00000; #1 chk("R4 manufacturer code", id_rdata, 8'hC2);
      rd_addr = 18'h00001; #1 chk("R4 device code", id_rdata, 8'hB0);
      rd_addr = 18'h20002; #1 chk("R5 protected sector 2", id_rdata, 8'h01);
      rd_addr = 18'h10002; #1 chk("R5 unprotected sector 1", id_rdata, 8'h00);
      rd_addr = 18'h3A002; #1 chk("R5 protected sector 5", id_rdata, 8'h01);

      // R6: reset from identifier mode
      wr(18'h12345, 8'hF0);
      chk("R6 reset valid", req_valid, 1'b1);
      chk("R6 reset op", req_op, 3'd0);
      chk("R6 mode read", cur_mode, 2'd0);
      rd_addr = 18'h00000; #1 chk("R4 zero outside ident", id_rdata, 8'h00);

      // R6: reset in the middle of an erase prefix
      unlock();
      wr(18'h00555, 8'h80);
      wr(18'h00555, 8'hAA);
      wr(18'h00555, 8'hF0);
      chk("R6 mid-sequence reset op", req_op, 3'd0);
      chk("R6 mid-sequence reset valid", req_valid, 1'b1);
      wr(18'h002AA, 8'h55);
      chk("R3 sequence restarted", req_valid, 1'b0);
      wr(18'h00555, 8'h10);
      chk("R3 no chip erase after reset", req_valid, 1'b0);
      chk("R3 still read", cur_mode, 2'd0);

      // R6 exception: F0 as program data
      unlock();
      wr(18'h00555, 8'hA0);
      wr(18'h01000, 8'hF0);
      chk("R6 program data F0 op", req_op, 3'd2);
      chk("R2 program addr", req_addr, 18'h01000);
      chk("R6 program data value", req_data, 8'hF0);
      chk("R2 busy after program", cur_mode, 2'd2);
      @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
      chk("R12 done returns read", cur_mode, 2'd0);

      // R8 / R9 / R10 / R11: sector erase, append, suspend, resume
      erase_prefix();
      wr(18'h3A000, 8'h30);
      chk("R8 sector erase op", req_op, 3'd4);
      chk("R8 sector 5 selected", erase_set, 7'b0100000);
      @(negedge clk);
      chk("R13 single pulse", req_valid, 1'b0);
      wr(18'h00000, 8'h30);
      chk("R9 append op", req_op, 3'd7);
      chk("R9 append valid", req_valid, 1'b1);
      chk("R9 set grows", erase_set, 7'b0100001);
      wr(18'h00000, 8'hB0);
      chk("R10 suspend op", req_op, 3'd5);
      chk("R10 suspended mode", cur_mode, 2'd3);
      wr(18'h00555, 8'hAA);
      chk("R11 ignored in suspend valid", req_valid, 1'b0);
      wr(18'h00000, 8'hF0);
      chk("R11 F0 ignored in suspend", cur_mode, 2'd3);
      chk("R11 F0 no request", req_valid, 1'b0);
      wr(18'h00000, 8'h30);
      chk("R11 resume op", req_op, 3'd6);
      chk("R11 busy after resume", cur_mode, 2'd2);
      repeat (12) @(negedge clk);
      wr(18'h10000, 8'h30);
      chk("R9 late append ignored", req_valid, 1'b0);
      chk("R9 set unchanged", erase_set, 7'b0100001);
      wr(18'h00000, 8'hF0);
      chk("R6 reset from busy op", req_op, 3'd0);
      chk("R6 reset clears set", erase_set, 7'd0);
      chk("R6 reset from busy mode", cur_mode, 2'd0);

      // R8: another sector, set held after completion
      erase_prefix();
      wr(18'h3C000, 8'h30);
      chk("R8 sector 6 selected", erase_set, 7'b1000000);
      @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
      chk("R12 done after sector erase", cur_mode, 2'd0);
      chk("R8 set held after done", erase_set, 7'b1000000);

      finish_run();
   end
endmodule